// File: doc/BRIEF.md
# Per-Channel Fault Latch and Alert Controller

This block keeps a six-bit fault word for each power channel of a hot-swap controller. Each bit latches one kind of event:

- overvoltage
- undervoltage
- overcurrent
- power-bad
- board-presence change
- FET short

It also holds a six-bit alert-enable word per channel. It drives an active-low alert request whenever a latched, enabled fault has not yet been acknowledged. Each bit has a private "already alerted" flag. A fault therefore pulls the alert line once per occurrence, and a continuing or repeated fault stays quiet until its bit has been cleared.

Power-bad and the UV-reset clear are qualified on chip. Each passes through a cycle-count filter of about 2 µs, derived from a clock-frequency parameter, and the filter restarts whenever its input drops. The bus engine sits outside the block. It supplies a register write port and two strobes: one for an acknowledged alert-response read and one for a direct address match. Fault bits can be cleared in several ways, but a bit whose live cause is still present cannot be cleared.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset every fault bit and every alert-enable bit is 0, `alert_n` is 1 and every `pb_n` bit is 1.
- R2: Fault bit positions are 0 overvoltage, 1 undervoltage, 2 overcurrent, 3 power-bad, 4 presence change and 5 FET short. The alert-enable word uses the same positions. An event pulse sets its bit one clock later. `alert_n` goes low only when some set fault bit has its enable bit at 1 and has not been alerted.
- R3: A pulse on `ara_ack` releases `alert_n` on the next clock. A pulse on `addr_hit` does the same while `alert_n` is low, and has no effect while it is high.
- R4: After a release, the same still-set fault bit does not pull `alert_n` low again. A newly set enabled bit does pull it low again. So does the released bit once it has been cleared and then set again.
- R5: A write with `wr_mask`=0 clears every fault bit of channel `wr_ch` whose `wr_data` bit is 0. Data bits of 1 leave fault bits unchanged. A write with `wr_mask`=1 loads the alert-enable word of that channel.
- R6: A fault bit whose live condition is still present stays set through any clear. The live conditions are `lvl_ov`/`lvl_uv`/`lvl_oc` for bits 0 to 2, qualified power-bad for bit 3, and `isense_hi` with `gate_off` for bit 5.
- R7: All six fault bits of a channel clear when `on_in` falls. They also clear when power-bad status drops because `gate_hi` went low.
- R8: All six fault bits of a channel clear once `uv_rst` has stayed high longer than the filter time (400 cycles at 200 MHz). A shorter pulse has no effect. `supply_lo` clears the fault bits of all channels at the next clock.
- R9: When `fb_low` and `gate_hi` are both held longer than the filter time, `pb_n` goes low and fault bit 3 sets. A shorter hold does nothing, and so does `fb_low` while `gate_hi` is low.
- R10: When `fb_low` drops, `pb_n` returns to 1 on the next clock while fault bit 3 stays set.
- R11: `isense_hi` together with `gate_off` sets fault bit 5. `isense_hi` with the gate on does not.
- R12: An event that arrives in the same clock as a clear leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ov | input | NCH | Overvoltage event pulse per channel |
| ev_uv | input | NCH | Undervoltage event pulse per channel |
| ev_oc | input | NCH | Overcurrent event pulse per channel |
| ev_en_chg | input | NCH | Board presence change pulse per channel |
| lvl_ov | input | NCH | Live overvoltage condition |
| lvl_uv | input | NCH | Live undervoltage condition |
| lvl_oc | input | NCH | Live overcurrent condition |
| fb_low | input | NCH | Feedback below power-good threshold |
| gate_hi | input | NCH | Gate drive above gate-to-source threshold |
| gate_off | input | NCH | Gate turned off |
| isense_hi | input | NCH | Sense voltage at or above short limit |
| on_in | input | NCH | Channel on command level |
| uv_rst | input | NCH | UV-reset level, filtered inside |
| supply_lo | input | 1 | Supply lockout, clears all channels |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 1 | 1 selects alert-enable word, 0 the fault word |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_data | input | 6 | Write data |
| ara_ack | input | 1 | Alert-response read acknowledged |
| addr_hit | input | 1 | Device directly addressed |
| fault | output | NCH*6 | Fault words, channel c at bits 6c+5..6c |
| pb_n | output | NCH | Power-bad output, low while power-bad |
| alert_n | output | 1 | Alert request, low while asserted |

## Verification
The alert path is driven with several patterns, each of which separates a distinct kind of error:

- A fault with its enable off shows whether the enable gates the alert at all.
- A repeat of an already-acknowledged fault shows whether the per-bit flag holds.
- A fault on a different bit shows whether re-arming depends on the bit or on the whole word.
- A clear followed by a repeat of the same bit shows whether the flag is dropped on clearing.
- An address match with no alert pending shows whether that strobe is qualified.

The power-bad and UV-reset filters get holds shorter and longer than the window, and a power-bad hold with the gate low. These tell a working filter from a missing or unqualified one. Clears are also tried against a live cause and against an event arriving in the same clock, which separates clear-priority from set-priority and resisting from non-resisting logic.

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl #(
  parameter int NCH     = 2,
  parameter int CLK_HZ  = 200_000_000,
  parameter int FILT_NS = 2000,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ev_ov,
  input  logic [NCH-1:0]   ev_uv,
  input  logic [NCH-1:0]   ev_oc,
  input  logic [NCH-1:0]   ev_en_chg,
  input  logic [NCH-1:0]   lvl_ov,
  input  logic [NCH-1:0]   lvl_uv,
  input  logic [NCH-1:0]   lvl_oc,
  input  logic [NCH-1:0]   fb_low,
  input  logic [NCH-1:0]   gate_hi,
  input  logic [NCH-1:0]   gate_off,
  input  logic [NCH-1:0]   isense_hi,
  input  logic [NCH-1:0]   on_in,
  input  logic [NCH-1:0]   uv_rst,
  input  logic             supply_lo,
  input  logic             wr_en,
  input  logic             wr_mask,
  input  logic [CHW-1:0]   wr_ch,
  input  logic [5:0]       wr_data,
  input  logic             ara_ack,
  input  logic             addr_hit,
  output logic [NCH*6-1:0] fault,
  output logic [NCH-1:0]   pb_n,
  output logic             alert_n
);
  localparam int NB       = 6;
  localparam int FILT_CYC = (CLK_HZ / 1000) * FILT_NS / 1_000_000;
  localparam int CW       = $clog2(FILT_CYC + 1);

  logic [NCH-1:0] pend;
  logic           rel;

  assign alert_n = ~|pend;
  assign rel     = ara_ack | (addr_hit & ~alert_n);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NB-1:0] flt, msk, alt;
    logic          pb_st, on_q;
    logic [CW-1:0] pb_cnt, uv_cnt;

    wire pb_in   = fb_low[c] & gate_hi[c];
    wire pb_filt = pb_in && (pb_cnt == CW'(FILT_CYC));
    wire uv_filt = uv_rst[c] && (uv_cnt == CW'(FILT_CYC));
    wire fet     = isense_hi[c] & gate_off[c];
    wire sel     = wr_en && (wr_ch == CHW'(c));

    wire [NB-1:0] set_v  = {fet, ev_en_chg[c], pb_filt, ev_oc[c], ev_uv[c], ev_ov[c]};
    wire [NB-1:0] live_v = {fet, 1'b0, pb_filt, lvl_oc[c], lvl_uv[c], lvl_ov[c]};
    wire [NB-1:0] hclr   = (sel && !wr_mask) ? ~wr_data : '0;
    wire          eclr   = (on_q & ~on_in[c]) | (pb_st & ~gate_hi[c]) | uv_filt | supply_lo;
    wire [NB-1:0] clr    = (hclr | {NB{eclr}}) & ~live_v;
    wire [NB-1:0] flt_nx = set_v | (flt & ~clr);
    wire [NB-1:0] acked  = rel ? (flt & msk) : '0;

    assign pend[c]          = |(flt & msk & ~alt);
    assign fault[c*NB +: NB] = flt;
    assign pb_n[c]          = ~pb_st;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt    <= '0;
        msk    <= '0;
        alt    <= '0;
        pb_st  <= 1'b0;
        on_q   <= 1'b0;
        pb_cnt <= '0;
        uv_cnt <= '0;
      end else begin
        flt   <= flt_nx;
        alt   <= flt_nx & (alt | acked);
        pb_st <= pb_filt;
        on_q  <= on_in[c];
        if (sel && wr_mask) msk <= wr_data;
        if (!pb_in) pb_cnt <= '0;
        else if (pb_cnt != CW'(FILT_CYC)) pb_cnt <= pb_cnt + 1'b1;
        if (!uv_rst[c]) uv_cnt <= '0;
        else if (uv_cnt != CW'(FILT_CYC)) uv_cnt <= uv_cnt + 1'b1;
      end
    end

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt[0] && lvl_ov[c]) |=> flt[0]);

    // R9
    pb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pb_n[c] |-> flt[3]);

    // R10
    pb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_low[c] |=> pb_n[c]);

    // R11
    fet_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isense_hi[c] && gate_off[c]) |=> flt[5]);
  end

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_ack && !wr_en) |=> (alert_n || !$stable(fault)));
endmodule

// File: tb/fault_alert_ctrl_test.sv
`timescale 1ns/1ps
module fault_alert_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [1:0] ev_ov, ev_uv, ev_oc, ev_en_chg, lvl_ov, lvl_uv, lvl_oc;
  logic [1:0] fb_low, gate_hi, gate_off, isense_hi, on_in, uv_rst;
  logic supply_lo, wr_en, wr_mask, ara_ack, addr_hit;
  logic [0:0] wr_ch;
  logic [5:0] wr_data;
  logic [11:0] fault;
  logic [1:0] pb_n;
  logic alert_n;

  int total = 0, fails = 0;
  bit done = 0;

  fault_alert_ctrl #(.NCH(2), .CLK_HZ(200_000_000), .FILT_NS(2000)) uut (
    .clk(clk), .rst_n(rst_n), .ev_ov(ev_ov), .ev_uv(ev_uv), .ev_oc(ev_oc),
    .ev_en_chg(ev_en_chg), .lvl_ov(lvl_ov), .lvl_uv(lvl_uv), .lvl_oc(lvl_oc),
    .fb_low(fb_low), .gate_hi(gate_hi), .gate_off(gate_off), .isense_hi(isense_hi),
    .on_in(on_in), .uv_rst(uv_rst), .supply_lo(supply_lo), .wr_en(wr_en),
    .wr_mask(wr_mask), .wr_ch(wr_ch), .wr_data(wr_data), .ara_ack(ara_ack),
    .addr_hit(addr_hit), .fault(fault), .pb_n(pb_n), .alert_n(alert_n));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] fw(input int c);
    return fault[c*6 +: 6];
  endfunction

  task automatic p_ov(input int c);  ev_ov[c] = 1'b1;     tick(1); ev_ov[c] = 1'b0;     endtask
  task automatic p_uv(input int c);  ev_uv[c] = 1'b1;     tick(1); ev_uv[c] = 1'b0;     endtask
  task automatic p_oc(input int c);  ev_oc[c] = 1'b1;     tick(1); ev_oc[c] = 1'b0;     endtask
  task automatic p_en(input int c);  ev_en_chg[c] = 1'b1; tick(1); ev_en_chg[c] = 1'b0; endtask
  task automatic ack();  ara_ack = 1'b1;  tick(1); ara_ack = 1'b0;  endtask
  task automatic hit();  addr_hit = 1'b1; tick(1); addr_hit = 1'b0; endtask

  task automatic host_wr(input logic m, input int c, input logic [5:0] d);
    wr_en = 1'b1; wr_mask = m; wr_ch = c[0:0]; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 fault", fault, 0);
    check("R1 alert_n", alert_n, 1);
    check("R1 pb_n", pb_n, 2'b11);
  endtask

  task automatic t_mask();
    p_ov(0);
    check("R2 ov bit", fw(0), 6'b000001);
    check("R2 masked off", alert_n, 1);
    host_wr(1'b1, 0, 6'b000011);
    check("R2 mask on alert", alert_n, 0);
  endtask

  task automatic t_release();
    ack();
    check("R3 ack release", alert_n, 1);
    p_ov(0);
    check("R4 same bit no reassert", alert_n, 1);
    p_uv(0);
    check("R4 new bit fault", fw(0), 6'b000011);
    check("R4 new bit reassert", alert_n, 0);
    hit();
    check("R3 addr release", alert_n, 1);
    hit();
    check("R3 addr idle", alert_n, 1);
    host_wr(1'b0, 0, 6'b111110);
    check("R5 clear bit0", fw(0), 6'b000010);
    check("R4 after clear", alert_n, 1);
    p_ov(0);
    check("R4 reassert after clear", alert_n, 0);
    ack();
    p_oc(0);
    check("R2 oc bit", fw(0), 6'b000111);
    check("R2 oc masked off", alert_n, 1);
  endtask

  task automatic t_write();
    host_wr(1'b0, 1, 6'b111111);
    check("R5 ones no set", fw(1), 6'b000000);
    host_wr(1'b0, 0, 6'b111111);
    check("R5 ones keep", fw(0), 6'b000111);
    host_wr(1'b0, 0, 6'b000000);
    check("R5 clear all", fw(0), 6'b000000);
  endtask

  task automatic t_resist();
    lvl_ov[0] = 1'b1;
    p_ov(0);
    host_wr(1'b0, 0, 6'b000000);
    check("R6 resist", fw(0), 6'b000001);
    check("R6 alert pending", alert_n, 0);
    lvl_ov[0] = 1'b0;
    host_wr(1'b0, 0, 6'b000000);
    check("R6 clear after live", fw(0), 6'b000000);
    check("R6 alert off", alert_n, 1);
  endtask

  task automatic t_prio();
    wr_en = 1'b1; wr_mask = 1'b0; wr_ch = 1'b0; wr_data = 6'b000000;
    ev_oc[0] = 1'b1;
    tick(1);
    wr_en = 1'b0; ev_oc[0] = 1'b0;
    check("R12 set wins", fw(0), 6'b000100);
    host_wr(1'b0, 0, 6'b000000);
  endtask

  task automatic t_on();
    p_en(1);
    p_oc(1);
    check("R7 ch1 set", fw(1), 6'b010100);
    on_in[1] = 1'b0;
    tick(1);
    check("R7 on fall clear", fw(1), 6'b000000);
    check("R7 ch0 untouched", fw(0), 6'b000000);
    on_in[1] = 1'b1;
    tick(1);
  endtask

  task automatic t_pb();
    gate_hi[0] = 1'b1; fb_low[0] = 1'b1;
    tick(300);
    fb_low[0] = 1'b0;
    tick(1);
    check("R9 short pb_n", pb_n[0], 1);
    check("R9 short fault", fw(0), 6'b000000);
    gate_hi[0] = 1'b0; fb_low[0] = 1'b1;
    tick(600);
    check("R9 gate low pb_n", pb_n[0], 1);
    check("R9 gate low fault", fw(0), 6'b000000);
    fb_low[0] = 1'b0; gate_hi[0] = 1'b1;
    tick(1);
    fb_low[0] = 1'b1;
    tick(500);
    check("R9 pb_n low", pb_n[0], 0);
    check("R9 fault3", fw(0), 6'b001000);
    check("R9 masked alert", alert_n, 1);
    fb_low[0] = 1'b0;
    tick(1);
    check("R10 pb_n release", pb_n[0], 1);
    check("R10 fault3 kept", fw(0), 6'b001000);
    fb_low[0] = 1'b1;
    tick(500);
    check("R9 pb again", pb_n[0], 0);
    gate_hi[0] = 1'b0;
    tick(1);
    check("R7 pb fall clear", fw(0), 6'b000000);
    check("R7 pb_n", pb_n[0], 1);
    fb_low[0] = 1'b0;
    tick(1);
  endtask

  task automatic t_uv();
    p_en(0);
    check("R8 en bit", fw(0), 6'b010000);
    uv_rst[0] = 1'b1;
    tick(300);
    uv_rst[0] = 1'b0;
    tick(1);
    check("R8 short uv keep", fw(0), 6'b010000);
    uv_rst[0] = 1'b1;
    tick(500);
    uv_rst[0] = 1'b0;
    check("R8 long uv clear", fw(0), 6'b000000);
    p_en(0);
    p_en(1);
    supply_lo = 1'b1;
    tick(1);
    supply_lo = 1'b0;
    check("R8 lockout clear", fault, 0);
  endtask

  task automatic t_fet();
    gate_off[1] = 1'b1;
    tick(2);
    check("R11 no sense", fw(1), 6'b000000);
    isense_hi[1] = 1'b1;
    tick(1);
    isense_hi[1] = 1'b0;
    check("R11 short set", fw(1), 6'b100000);
    isense_hi[0] = 1'b1;
    tick(1);
    isense_hi[0] = 1'b0;
    check("R11 gate on no set", fw(0), 6'b000000);
    gate_off[1] = 1'b0;
    host_wr(1'b0, 1, 6'b000000);
    check("R11 cleared", fw(1), 6'b000000);
  endtask

  initial begin
    rst_n = 1'b0;
    {ev_ov, ev_uv, ev_oc, ev_en_chg, lvl_ov, lvl_uv, lvl_oc} = '0;
    {fb_low, gate_hi, gate_off, isense_hi, uv_rst} = '0;
    on_in = 2'b11;
    supply_lo = 1'b0; wr_en = 1'b0; wr_mask = 1'b0; wr_ch = 1'b0; wr_data = '0;
    ara_ack = 1'b0; addr_hit = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_mask();
    t_release();
    t_write();
    t_resist();
    t_prio();
    t_on();
    t_pb();
    t_uv();
    t_fet();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule